// File: doc/BRIEF.md
# Infrared Raw Symbol Capture Receiver

This block samples the output of an infrared demodulator and measures the signal one symbol at a time. A symbol opens on a rising edge of the input. It is timed as a high (pulse) phase followed by a low (space) phase, both counted in ticks of a programmable divider. Each completed symbol is packed into one 32-bit word and placed in a small FIFO. Software reads the words back through a simple memory-mapped register port.

A symbol is closed in one of two ways. The normal way is the next rising edge of the input. The other way is reaching the configured maximum width: once pulse plus space reaches that width, the stream is taken as ended and a timeout event is raised. Three sticky events drive a single interrupt line through a mask:

- symbol received, raised at a programmable FIFO fill level;
- timeout;
- overflow.

On overflow the words already queued are kept, and software drains them before clearing the flag.

Top module: `ir_capture_rx`

## Requirements
- R1: After reset the configuration reads 0x3E80_0080, the mask reads 0x7, and the FIFO count, status, busy flag and `irq` are all 0.
- R2: The receiver is on only when enable bit 0 is set and, with `NEED_EXTRA_EN`=1, enable bit 8 is also set. Turning it on makes the busy register (offset 0x1C) read 1 for `BUSY_CYCLES` cycles. While busy, configuration writes are ignored.
- R3: Capture starts only after a write to the start register (offset 0x34) while the receiver is on. A symbol begins at a rising edge of `ir_in`. Its word holds the pulse ticks in bits 15:0 and the space ticks in bits 31:16.
- R4: When pulse plus space reaches the maximum width (config bits 31:16), the symbol is stored with space = maximum − pulse, capture waits for a new rising edge, and the timeout event is raised.
- R5: Reading offset 0x20 returns the FIFO count. Each read of offset 0x24 returns and removes the oldest word, in arrival order. A read of 0x24 while the FIFO is empty returns 0.
- R6: The symbol-received event is raised by a stored word that leaves the count at or above the level field (config bits 13:8) plus one.
- R7: A symbol completing while the FIFO (depth `DEPTH`) is full is dropped and raises overflow. The queued words stay unchanged and readable.
- R8: Status (offset 0x2C) shows received at bits 24 and 8, timeout at bits 25 and 9, and overflow at bits 26 and 10. Writing 1 to bits 16, 17 or 18 of offset 0x30 clears received, timeout or overflow respectively.
- R9: `irq` is the OR of the status events whose mask bit (offset 0x28: bit 0 received, bit 1 timeout, bit 2 overflow) is 0.
- R10: Widths are counted in ticks of one per (config bits 6:0 + 1) system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated infrared level, asynchronous |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a full FIFO that is still taking symbols. It needs sixteen completed symbols, then more arriving before any read, with the last one closed by the width limit rather than by an edge. The stimulus streams eighteen symbols with distinct pulse widths back to back and then holds the line low past the limit. This produces two dropped words together with received, timeout and overflow all pending. Draining then confirms that the first sixteen words survived in order. The timeout word's space field is checked against the maximum width minus its pulse.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;
  localparam int unsigned WID_W = 16;

  localparam int unsigned OFF_EN    = 'h00;
  localparam int unsigned OFF_CFG   = 'h04;
  localparam int unsigned OFF_BUSY  = 'h1C;
  localparam int unsigned OFF_COUNT = 'h20;
  localparam int unsigned OFF_POP   = 'h24;
  localparam int unsigned OFF_MASK  = 'h28;
  localparam int unsigned OFF_STS   = 'h2C;
  localparam int unsigned OFF_CLR   = 'h30;
  localparam int unsigned OFF_START = 'h34;

  localparam logic [31:0] CFG_RESET = 32'h3E80_0080;

  typedef enum logic [1:0] {M_IDLE, M_PULSE, M_SPACE} meas_state_e;

  // one symbol word: space in the upper half, pulse in the lower half
  function automatic logic [31:0] pack_symbol(input logic [WID_W-1:0] pulse,
                                              input logic [WID_W-1:0] space);
    return {space, pulse};
  endfunction

  function automatic logic [WID_W-1:0] sat_inc(input logic [WID_W-1:0] v);
    return (v == {WID_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  function automatic logic at_limit(input logic [WID_W-1:0] pulse,
                                    input logic [WID_W-1:0] space,
                                    input logic [WID_W-1:0] maxw);
    return ({1'b0, pulse} + {1'b0, space}) >= {1'b0, maxw};
  endfunction

  // events {ovf,tmo,rx} mirrored into two byte lanes
  function automatic logic [31:0] status_word(input logic [2:0] ev);
    return {5'd0, ev, 13'd0, ev, 8'd0};
  endfunction
endpackage

// File: rtl/ir_tick_gen.sv
module ir_tick_gen #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_m1,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || tick)   cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ir_symbol_meas.sv
module ir_symbol_meas
  import ir_cap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             ir_lvl,
  input  logic [WID_W-1:0] maxw,
  output logic             sym_valid,
  output logic [31:0]      sym_word,
  output logic             tmo_evt
);
  meas_state_e      st;
  logic             ir_d;
  logic [WID_W-1:0] pulse_q, space_q;
  logic             rise, fall, limit;

  assign rise  = ir_lvl & ~ir_d;
  assign fall  = ~ir_lvl & ir_d;
  assign limit = at_limit(pulse_q, space_q, maxw);

  assign sym_valid = run && (st == M_SPACE) && (rise || limit);
  assign tmo_evt   = run && (st == M_SPACE) && limit && !rise;
  assign sym_word  = pack_symbol(pulse_q, space_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= M_IDLE;
      ir_d    <= 1'b0;
      pulse_q <= '0;
      space_q <= '0;
    end else begin
      ir_d <= ir_lvl;
      if (!run) begin
        st <= M_IDLE;
      end else begin
        unique case (st)
          M_IDLE: if (rise) begin
            st      <= M_PULSE;
            pulse_q <= WID_W'(1);
          end
          M_PULSE: begin
            if (fall) begin
              st      <= M_SPACE;
              space_q <= WID_W'(1);
            end else if (tick) begin
              pulse_q <= sat_inc(pulse_q);
            end
          end
          M_SPACE: begin
            if (rise) begin
              st      <= M_PULSE;
              pulse_q <= WID_W'(1);
            end else if (limit) begin
              st <= M_IDLE;
            end else if (tick) begin
              space_q <= sat_inc(space_q);
            end
          end
          default: st <= M_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ir_sym_fifo.sv
module ir_sym_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = empty ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/ir_capture_rx.sv
module ir_capture_rx
  import ir_cap_pkg::*;
#(
  parameter int unsigned DEPTH         = 16,
  parameter bit          NEED_EXTRA_EN = 1'b1,
  parameter int unsigned BUSY_CYCLES   = 4,
  parameter int unsigned ADDR_W        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int unsigned CW     = $clog2(DEPTH + 1);
  localparam int unsigned BUSY_W = $clog2(BUSY_CYCLES + 1);
  localparam int unsigned DIV_W  = 7;

  // register access decode
  logic wr, rd;
  logic wr_en, wr_cfg, wr_mask, wr_clr, wr_start, rd_pop;
  assign wr       = bus_sel && bus_we;
  assign rd       = bus_sel && !bus_we;
  assign wr_en    = wr && (bus_addr == ADDR_W'(OFF_EN));
  assign wr_cfg   = wr && (bus_addr == ADDR_W'(OFF_CFG));
  assign wr_mask  = wr && (bus_addr == ADDR_W'(OFF_MASK));
  assign wr_clr   = wr && (bus_addr == ADDR_W'(OFF_CLR));
  assign wr_start = wr && (bus_addr == ADDR_W'(OFF_START));
  assign rd_pop   = rd && (bus_addr == ADDR_W'(OFF_POP));

  // enable and bring-up
  logic              en_main, en_extra, rx_on, wr_turns_on, busy, running, capture_on;
  logic [BUSY_W-1:0] busy_cnt;

  function automatic logic on_from(input logic m, input logic x);
    return m && (x || !NEED_EXTRA_EN);
  endfunction

  assign rx_on       = on_from(en_main, en_extra);
  assign wr_turns_on = wr_en && on_from(bus_wdata[0], bus_wdata[8]) && !rx_on;
  assign busy        = (busy_cnt != '0);
  assign capture_on  = running && rx_on && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_main  <= 1'b0;
      en_extra <= 1'b0;
      busy_cnt <= '0;
      running  <= 1'b0;
    end else begin
      if (wr_en) begin
        en_main  <= bus_wdata[0];
        en_extra <= bus_wdata[8];
      end
      if (wr_turns_on)  busy_cnt <= BUSY_W'(BUSY_CYCLES);
      else if (busy)    busy_cnt <= busy_cnt - 1'b1;
      if (!rx_on)                     running <= 1'b0;
      else if (wr_start && !busy)     running <= 1'b1;
    end
  end

  // configuration
  logic [31:0]      cfg;
  logic             cfg_wr_ok;
  logic [WID_W-1:0] cfg_maxw;
  logic [5:0]       cfg_level;
  logic [DIV_W-1:0] cfg_div;
  assign cfg_wr_ok = wr_cfg && !busy;
  assign cfg_maxw  = cfg[31:16];
  assign cfg_level = cfg[13:8];
  assign cfg_div   = cfg[DIV_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cfg <= CFG_RESET;
    else if (cfg_wr_ok) cfg <= bus_wdata;
  end

  // input synchroniser
  logic ir_s1, ir_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_s1 <= 1'b0;
      ir_s2 <= 1'b0;
    end else begin
      ir_s1 <= ir_in;
      ir_s2 <= ir_s1;
    end
  end

  // measurement datapath
  logic        tick, sym_valid, tmo_evt;
  logic [31:0] sym_word;

  ir_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(capture_on), .div_m1(cfg_div), .tick(tick)
  );

  ir_symbol_meas u_meas (
    .clk(clk), .rst_n(rst_n), .run(capture_on), .tick(tick), .ir_lvl(ir_s2),
    .maxw(cfg_maxw), .sym_valid(sym_valid), .sym_word(sym_word), .tmo_evt(tmo_evt)
  );

  logic [31:0]   fifo_dout;
  logic [CW-1:0] fifo_count;
  logic          fifo_full, fifo_empty, push_ok, pop_ok, ovf_evt, rx_evt;

  assign push_ok = sym_valid && !fifo_full;
  assign ovf_evt = sym_valid && fifo_full;
  assign pop_ok  = rd_pop && !fifo_empty;
  assign rx_evt  = push_ok && ({{(32-CW){1'b0}}, fifo_count} >= {26'd0, cfg_level});

  ir_sym_fifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(sym_valid), .din(sym_word), .pop(rd_pop),
    .dout(fifo_dout), .count(fifo_count), .full(fifo_full), .empty(fifo_empty)
  );

  // events: bit 0 received, bit 1 timeout, bit 2 overflow
  logic [2:0] sts, mask, ev_set, ev_clr;
  assign ev_set = {ovf_evt, tmo_evt, rx_evt};
  assign ev_clr = wr_clr ? bus_wdata[18:16] : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts  <= '0;
      mask <= 3'b111;
    end else begin
      sts <= (sts & ~ev_clr) | ev_set;
      if (wr_mask) mask <= bus_wdata[2:0];
    end
  end

  assign irq = |(sts & ~mask);

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      unique case (int'(bus_addr))
        OFF_EN:    bus_rdata = {23'd0, en_extra, 7'd0, en_main};
        OFF_CFG:   bus_rdata = cfg;
        OFF_BUSY:  bus_rdata = {31'd0, busy};
        OFF_COUNT: bus_rdata = {{(32-CW){1'b0}}, fifo_count};
        OFF_POP:   bus_rdata = fifo_dout;
        OFF_MASK:  bus_rdata = {29'd0, mask};
        OFF_STS:   bus_rdata = status_word(sts);
        default:   bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ir_capture_rx_checker.sv
module ir_capture_rx_checker #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sym_valid,
  input logic          push_ok,
  input logic          pop_ok,
  input logic          fifo_full,
  input logic [CW-1:0] fifo_count,
  input logic          tmo_evt,
  input logic [2:0]    sts,
  input logic [2:0]    mask,
  input logic          irq,
  input logic          wr_cfg,
  input logic          busy,
  input logic [31:0]   cfg
);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CW'(DEPTH));

  assert_full_drop_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && fifo_full) |=> sts[2]);

  assert_no_overflow_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && fifo_full && !pop_ok) |=> (fifo_count == $past(fifo_count)));

  assert_pop_decrements_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok) |=> (fifo_count == $past(fifo_count) - CW'(1)));

  assert_timeout_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> sts[1]);

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 3'b111) |-> !irq);

  assert_busy_blocks_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cfg && busy) |=> $stable(cfg));
endmodule

bind ir_capture_rx ir_capture_rx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .push_ok(push_ok), .pop_ok(pop_ok),
  .fifo_full(fifo_full), .fifo_count(fifo_count), .tmo_evt(tmo_evt), .sts(sts),
  .mask(mask), .irq(irq), .wr_cfg(wr_cfg), .busy(busy), .cfg(cfg)
);

// File: tb/ir_capture_rx_bench.sv
module ir_capture_rx_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ir_capture_rx u_ir_capture_rx (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [31:0] cfg_word(input int maxw, input int lvl, input int div);
    return (32'(maxw) << 16) | (32'(lvl) << 8) | 32'h80 | 32'(div);
  endfunction

  function automatic logic [31:0] sts_word(input logic [2:0] ev);
    return (32'(ev) << 24) | (32'(ev) << 8);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_sym(input int h, input int l);
    @(negedge clk);
    ir_in = 1'b1;
    for (int i = 1; i < h; i++) @(negedge clk);
    @(negedge clk);
    ir_in = 1'b0;
    for (int i = 1; i < l; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(6'h04, d); check("R1 config", d, 32'h3E80_0080);
    rd(6'h28, d); check("R1 mask", d, 32'h7);
    rd(6'h20, d); check("R1 count", d, 0);
    rd(6'h2C, d); check("R1 status", d, 0);
    rd(6'h1C, d); check("R1 busy", d, 0);
    check("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    wr(6'h00, 32'h1);
    wr(6'h34, 32'h1);
    send_sym(4, 4);
    idle(150);
    rd(6'h20, d); check("R2 single enable bit stays off", d, 0);
    wr(6'h00, 32'h101);
    rd(6'h1C, d); check("R2 busy after turn-on", d, 1);
    wr(6'h04, cfg_word(100, 0, 0));
    rd(6'h04, d); check("R2 config ignored while busy", d, 32'h3E80_0080);
    idle(8);
    rd(6'h1C, d); check("R2 busy clears", d, 0);
    wr(6'h04, cfg_word(100, 0, 0));
    rd(6'h04, d); check("R2 config accepted", d, cfg_word(100, 0, 0));
    send_sym(4, 4);
    idle(150);
    rd(6'h20, d); check("R3 no capture before start", d, 0);
    wr(6'h34, 32'h5A);
  endtask

  task automatic t_order;
    logic [31:0] d;
    send_sym(5, 7);
    send_sym(9, 3);
    send_sym(6, 12);
    idle(150);
    rd(6'h20, d); check("R5 count", d, 3);
    rd(6'h24, d); check("R3 first word", d, {16'd7, 16'd5});
    rd(6'h24, d); check("R3 second word", d, {16'd3, 16'd9});
    rd(6'h24, d); check("R4 timeout word", d, {16'd94, 16'd6});
    rd(6'h20, d); check("R5 drained", d, 0);
    rd(6'h24, d); check("R5 empty pop zero", d, 0);
    rd(6'h2C, d); check("R8 rx+tmo status", d, sts_word(3'b011));
    wr(6'h30, 32'h0002_0000);
    rd(6'h2C, d); check("R8 clear timeout only", d, sts_word(3'b001));
    wr(6'h30, 32'h0001_0000);
    rd(6'h2C, d); check("R8 clear received", d, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    send_sym(3, 3);
    idle(150);
    check("R9 masked irq low", {31'd0, irq}, 0);
    wr(6'h28, 32'h6);
    check("R9 rx unmasked irq high", {31'd0, irq}, 1);
    wr(6'h30, 32'h0001_0000);
    check("R9 tmo still masked", {31'd0, irq}, 0);
    wr(6'h28, 32'h0);
    check("R9 all unmasked", {31'd0, irq}, 1);
    wr(6'h30, 32'h0007_0000);
    check("R9 cleared irq low", {31'd0, irq}, 0);
    rd(6'h24, d);
    wr(6'h28, 32'h7);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(6'h04, cfg_word(100, 2, 0));
    send_sym(3, 3);
    send_sym(3, 3);
    send_sym(3, 3);
    idle(5);
    rd(6'h20, d); check("R6 two stored", d, 2);
    rd(6'h2C, d); check("R6 below level no rx", d, 0);
    idle(150);
    rd(6'h2C, d); check("R6 level reached rx", d, sts_word(3'b011));
    for (int i = 0; i < 3; i++) rd(6'h24, d);
    wr(6'h30, 32'h0007_0000);
    wr(6'h04, cfg_word(100, 0, 0));
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    for (int i = 0; i < 18; i++) send_sym(i + 2, 3);
    idle(150);
    rd(6'h20, d); check("R7 count full", d, 16);
    rd(6'h2C, d); check("R7 overflow status", d, sts_word(3'b111));
    for (int i = 0; i < 16; i++) begin
      rd(6'h24, d); check($sformatf("R7 kept word %0d", i), d, {16'd3, 16'(i + 2)});
    end
    rd(6'h20, d); check("R7 drained", d, 0);
    wr(6'h30, 32'h0007_0000);
    rd(6'h2C, d); check("R8 all cleared", d, 0);
  endtask

  task automatic t_divider;
    logic [31:0] d;
    wr(6'h04, cfg_word(100, 0, 3));
    send_sym(40, 40);
    idle(600);
    rd(6'h20, d); check("R10 one word", d, 1);
    rd(6'h24, d);
    check("R10 pulse in ticks", {31'd0, (d[15:0] >= 16'd10) && (d[15:0] <= 16'd11)}, 1);
    check("R10 sum at limit", 32'(d[15:0]) + 32'(d[31:16]), 100);
    wr(6'h30, 32'h0007_0000);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_enable;
    t_order;
    t_irq;
    t_level;
    t_overflow;
    t_divider;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule